// File: doc/BRIEF.md
# Input Capture Unit with Spike Filter

This block records the moment an external event happens. A free-running counter value comes in on `cnt_val`. When the chosen edge appears on the chosen event source, the block copies that counter value into a capture register. It also raises a sticky capture flag, which stays up until it is cleared.

The event source is one of two inputs, selected by `src_sel`: a dedicated capture pin or the output of an analog comparator. Whichever source is selected goes through a two-flop synchronizer. Next comes an optional spike filter, which accepts a new level only after several consecutive identical samples. Edge detection follows, and `edge_rise` sets its polarity.

Software can also write the capture register. With `top_mode` set, the register serves as a fixed period limit for the timer: capture events are then ignored, and the register keeps the written value.

Top module: `evt_capture_unit`

## Requirements
- R1: With the filter off, a selected edge on the selected input loads `cap_val` with the `cnt_val` value present at the second rising clock edge after the edge that first samples the changed input. `cap_val` does not change before that clock edge.
- R2: `edge_rise`=1 captures on low-to-high transitions and `edge_rise`=0 captures on high-to-low transitions. A transition of the opposite direction loads nothing and leaves the flag low.
- R3: `src_sel`=0 takes events from `pin_evt` and `src_sel`=1 takes events from `cmp_evt`. Transitions on the unselected input have no effect on `cap_val` or `cap_flag`.
- R4: With `filt_en`=1, a new input level is accepted after 4 consecutive identical samples. This adds exactly 4 cycles to the R1 latency, so the captured value is the counter 6 cycles after the first sampling edge.
- R5: With the filter on, an input pulse held for 3 cycles produces no capture, while a pulse held for 4 cycles is captured. With the filter off, a 1-cycle pulse is captured.
- R6: Every capture sets `cap_flag`. The flag stays set until `flag_clr` is asserted for one cycle. A capture in the same cycle as `flag_clr` leaves the flag set.
- R7: `cap_wr_en`=1 loads `cap_wr_data` into `cap_val` at the next clock edge. A write in the same cycle as a capture takes priority over the capture.
- R8: While `top_mode`=1, capture events change neither `cap_val` nor `cap_flag`, and a written value is held.
- R9: Synchronous reset clears `cap_val` to 0 and `cap_flag` to 0, and forces the internal event level low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_sel | input | 1 | 0 = capture pin, 1 = comparator output |
| edge_rise | input | 1 | 1 = rising edge, 0 = falling edge |
| filt_en | input | 1 | Enables the 4-sample spike filter |
| top_mode | input | 1 | Capture register held as timer period limit |
| cnt_val | input | 16 | Free-running counter value |
| pin_evt | input | 1 | Asynchronous capture pin |
| cmp_evt | input | 1 | Asynchronous comparator output |
| cap_wr_en | input | 1 | Software write strobe for capture register |
| cap_wr_data | input | 16 | Software write data |
| flag_clr | input | 1 | Clears the capture flag |
| cap_val | output | 16 | Capture register contents |
| cap_flag | output | 1 | Sticky capture flag |

## Verification
The assertions check these properties on every cycle:
- a detected edge loads the counter value and raises the flag;
- the register and the flag hold when nothing acts on them;
- a write beats a capture;
- `top_mode` freezes both the register and the flag;
- a detected edge never repeats on the following cycle.

The end-to-end latency through the synchronizer and the filter is visible only in the bench scenarios, which sample the outputs at the exact cycles that R1 and R4 predict. The same holds for pulse-width rejection, polarity, and source selection at the pins.

// File: rtl/evt_capture_pkg.sv
package evt_capture_pkg;

    localparam int unsigned DEF_CNT_W    = 16;
    localparam int unsigned DEF_SYNC_LEN = 2;
    localparam int unsigned DEF_FILT_LEN = 4;

    typedef enum logic {
        SRC_PIN = 1'b0,
        SRC_CMP = 1'b1
    } evt_src_e;

    typedef enum logic {
        POL_FALL = 1'b0,
        POL_RISE = 1'b1
    } evt_pol_e;

    typedef struct packed {
        evt_src_e src;
        evt_pol_e pol;
        logic     filt_on;
        logic     hold_top;
    } evt_cfg_t;

    function automatic logic pick_source(evt_src_e src, logic pin, logic cmp);
        return (src == SRC_CMP) ? cmp : pin;
    endfunction

    function automatic logic edge_seen(evt_pol_e pol, logic now_lvl, logic old_lvl);
        if (pol == POL_RISE) return now_lvl & ~old_lvl;
        return ~now_lvl & old_lvl;
    endfunction

endpackage

// File: rtl/evt_sync.sv
module evt_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= din;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= {chain_q[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/evt_spike_filter.sv
module evt_spike_filter #(
    parameter int unsigned LEN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic din,
    output logic dout
);
    localparam int unsigned RUN_W = (LEN > 2) ? $clog2(LEN) : 1;

    logic lvl_q;

    generate
        if (LEN < 2) begin : g_bypass
            always_ff @(posedge clk) begin
                if (rst) lvl_q <= 1'b0;
                else     lvl_q <= din;
            end
        end else begin : g_vote
            logic [RUN_W-1:0] run_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    lvl_q <= 1'b0;
                    run_q <= '0;
                end else if (din == lvl_q) begin
                    run_q <= '0;
                end else if (run_q == RUN_W'(LEN - 1)) begin
                    lvl_q <= din;
                    run_q <= '0;
                end else begin
                    run_q <= run_q + 1'b1;
                end
            end
        end
    endgenerate

    assign dout = en ? lvl_q : din;
endmodule

// File: rtl/evt_edge_det.sv
module evt_edge_det
    import evt_capture_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     lvl,
    input  evt_pol_e pol,
    output logic     hit
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= lvl;
    end

    assign hit = edge_seen(pol, lvl, prev_q);
endmodule

// File: rtl/evt_cap_store.sv
module evt_cap_store #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         hit,
    input  logic         hold_top,
    input  logic [W-1:0] cnt,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         flag_clr,
    output logic [W-1:0] cap_q,
    output logic         flag_q
);
    logic take;

    assign take = hit & ~hold_top;

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_q <= '0;
        end else if (wr_en) begin
            cap_q <= wr_data;
        end else if (take) begin
            cap_q <= cnt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else if (take) begin
            flag_q <= 1'b1;
        end else if (flag_clr) begin
            flag_q <= 1'b0;
        end
    end
endmodule

// File: rtl/evt_capture_unit.sv
module evt_capture_unit
    import evt_capture_pkg::*;
#(
    parameter int unsigned CNT_W    = DEF_CNT_W,
    parameter int unsigned SYNC_LEN = DEF_SYNC_LEN,
    parameter int unsigned FILT_LEN = DEF_FILT_LEN
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             src_sel,
    input  logic             edge_rise,
    input  logic             filt_en,
    input  logic             top_mode,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             pin_evt,
    input  logic             cmp_evt,
    input  logic             cap_wr_en,
    input  logic [CNT_W-1:0] cap_wr_data,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] cap_val,
    output logic             cap_flag
);
    evt_cfg_t cfg;
    logic     raw_evt;
    logic     sync_lvl;
    logic     filt_lvl;
    logic     edge_hit_w;

    always_comb begin
        cfg.src      = evt_src_e'(src_sel);
        cfg.pol      = evt_pol_e'(edge_rise);
        cfg.filt_on  = filt_en;
        cfg.hold_top = top_mode;
    end

    assign raw_evt = pick_source(cfg.src, pin_evt, cmp_evt);

    evt_sync #(.STAGES(SYNC_LEN)) sync_i (
        .clk  (clk),
        .rst  (rst),
        .din  (raw_evt),
        .dout (sync_lvl)
    );

    evt_spike_filter #(.LEN(FILT_LEN)) filt_i (
        .clk  (clk),
        .rst  (rst),
        .en   (cfg.filt_on),
        .din  (sync_lvl),
        .dout (filt_lvl)
    );

    evt_edge_det edge_i (
        .clk (clk),
        .rst (rst),
        .lvl (filt_lvl),
        .pol (cfg.pol),
        .hit (edge_hit_w)
    );

    evt_cap_store #(.W(CNT_W)) store_i (
        .clk      (clk),
        .rst      (rst),
        .hit      (edge_hit_w),
        .hold_top (cfg.hold_top),
        .cnt      (cnt_val),
        .wr_en    (cap_wr_en),
        .wr_data  (cap_wr_data),
        .flag_clr (flag_clr),
        .cap_q    (cap_val),
        .flag_q   (cap_flag)
    );
endmodule

// File: rtl/evt_capture_chk.sv
module evt_capture_chk #(
    parameter int unsigned CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             hit,
    input logic             top_mode,
    input logic [CNT_W-1:0] cnt_val,
    input logic             wr_en,
    input logic [CNT_W-1:0] wr_data,
    input logic             flag_clr,
    input logic [CNT_W-1:0] cap_val,
    input logic             cap_flag
);
    AST_CAPTURE_LOADS: assert property (@(posedge clk) disable iff (rst)
        hit && !top_mode && !wr_en |=> cap_val == $past(cnt_val)); // R1
    AST_EDGE_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
        hit |=> !hit); // R2
    AST_FLAG_ON_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        hit && !top_mode |=> cap_flag); // R6
    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !(hit && !top_mode) && !flag_clr |=> $stable(cap_flag)); // R6
    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> cap_val == $past(wr_data)); // R7
    AST_TOP_KEEPS_VALUE: assert property (@(posedge clk) disable iff (rst)
        top_mode && !wr_en |=> $stable(cap_val)); // R8
    AST_TOP_NO_FLAG: assert property (@(posedge clk) disable iff (rst)
        top_mode && !flag_clr |=> $stable(cap_flag)); // R8
    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (cap_val == '0) && !cap_flag); // R9
endmodule

bind evt_capture_unit evt_capture_chk #(.CNT_W(CNT_W)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .hit      (edge_hit_w),
    .top_mode (top_mode),
    .cnt_val  (cnt_val),
    .wr_en    (cap_wr_en),
    .wr_data  (cap_wr_data),
    .flag_clr (flag_clr),
    .cap_val  (cap_val),
    .cap_flag (cap_flag)
);

// File: tb/evt_capture_unit_tb.sv
module evt_capture_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int SYNC_LAT   = 2;
    localparam int FILT_LAT   = 4;

    logic        clk = 1'b0;
    logic        rst, src_sel, edge_rise, filt_en, top_mode;
    logic [15:0] cnt_val;
    logic        pin_evt, cmp_evt, cap_wr_en, flag_clr;
    logic [15:0] cap_wr_data;
    logic [15:0] cap_val;
    logic        cap_flag;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    evt_capture_unit dut_i (
        .clk(clk), .rst(rst), .src_sel(src_sel), .edge_rise(edge_rise),
        .filt_en(filt_en), .top_mode(top_mode), .cnt_val(cnt_val),
        .pin_evt(pin_evt), .cmp_evt(cmp_evt), .cap_wr_en(cap_wr_en),
        .cap_wr_data(cap_wr_data), .flag_clr(flag_clr),
        .cap_val(cap_val), .cap_flag(cap_flag)
    );

    function automatic int lat_of(bit filt);
        return SYNC_LAT + (filt ? FILT_LAT : 0);
    endfunction

    function automatic bit edge_match(bit rise, bit old_l, bit new_l);
        return rise ? (!old_l && new_l) : (old_l && !new_l);
    endfunction

    function automatic logic [15:0] exp_cap(logic [15:0] v, bit filt);
        return v + 16'(lat_of(filt));
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        cnt_val = cnt_val + 16'd1;
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic set_in(bit sel, bit val);
        if (sel) cmp_evt = val; else pin_evt = val;
    endtask

    task automatic clear_flag();
        flag_clr = 1'b1; tick(); flag_clr = 1'b0;
    endtask

    task automatic run_event(bit sel, bit val, bit expect_hit, string req);
        logic [15:0] old_cap, v;
        int lat;
        clear_flag();
        old_cap = cap_val;
        lat = lat_of(filt_en);
        set_in(sel, val);
        v = cnt_val;
        ticks(lat);
        check({req, " no early load"}, 32'(cap_val), 32'(old_cap));
        tick();
        check({req, " value"}, 32'(cap_val), expect_hit ? 32'(exp_cap(v, filt_en)) : 32'(old_cap));
        check({req, " flag"}, 32'(cap_flag), 32'(expect_hit));
        ticks(8);
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            report();
            $finish;
        end
    end

    initial begin
        logic [15:0] v, old_cap;
        void'($urandom(32'd20240611));
        rst = 1; src_sel = 0; edge_rise = 1; filt_en = 0; top_mode = 0;
        cnt_val = 16'h0100; pin_evt = 0; cmp_evt = 0;
        cap_wr_en = 0; cap_wr_data = 0; flag_clr = 0;
        ticks(3);
        rst = 0;
        tick();
        check("R9 reset cap", 32'(cap_val), 32'h0);
        check("R9 reset flag", 32'(cap_flag), 32'h0);

        // R1 basic rising capture from pin
        run_event(0, 1, 1, "R1 pin rise");
        // R6 explicit clear
        clear_flag();
        check("R6 clear", 32'(cap_flag), 32'h0);
        // R2 falling polarity
        edge_rise = 0;
        run_event(0, 0, 1, "R2 falling edge");
        run_event(0, 1, 0, "R2 opposite edge ignored");
        edge_rise = 1;
        run_event(0, 0, 0, "R2 fall ignored in rise mode");
        // R3 source select
        src_sel = 1;
        run_event(1, 1, 1, "R3 cmp selected");
        run_event(0, 1, 0, "R3 pin unselected");
        run_event(1, 0, 0, "R3 cmp fall no hit");
        run_event(0, 0, 0, "R3 pin unselected fall");
        src_sel = 0;
        // R4 filter latency
        filt_en = 1;
        run_event(0, 1, 1, "R4 filtered rise");
        run_event(0, 0, 0, "R4 filtered fall");
        // R5 spikes with filter on
        clear_flag();
        old_cap = cap_val;
        pin_evt = 1; ticks(3); pin_evt = 0; ticks(12);
        check("R5 3-cycle spike value", 32'(cap_val), 32'(old_cap));
        check("R5 3-cycle spike flag", 32'(cap_flag), 32'h0);
        pin_evt = 1; v = cnt_val; ticks(4); pin_evt = 0; ticks(3);
        check("R5 4-cycle pulse value", 32'(cap_val), 32'(exp_cap(v, 1)));
        check("R5 4-cycle pulse flag", 32'(cap_flag), 32'h1);
        ticks(12);
        // R5 spike with filter off
        filt_en = 0;
        clear_flag();
        pin_evt = 1; v = cnt_val; tick(); pin_evt = 0; ticks(2);
        check("R5 unfiltered 1-cycle pulse", 32'(cap_val), 32'(exp_cap(v, 0)));
        ticks(8);
        // R6 capture beats clear in same cycle
        run_event(0, 1, 1, "R6 prime flag");
        pin_evt = 0; ticks(8);
        pin_evt = 1; v = cnt_val; ticks(SYNC_LAT);
        flag_clr = 1; tick(); flag_clr = 0;
        check("R6 set wins over clear", 32'(cap_flag), 32'h1);
        check("R6 value with clear", 32'(cap_val), 32'(exp_cap(v, 0)));
        pin_evt = 0; ticks(8);
        // R7 plain write and write beats capture
        cap_wr_en = 1; cap_wr_data = 16'hBEEF; tick(); cap_wr_en = 0;
        check("R7 write", 32'(cap_val), 32'hBEEF);
        pin_evt = 1; ticks(SYNC_LAT);
        cap_wr_en = 1; cap_wr_data = 16'h5A5A; tick(); cap_wr_en = 0;
        check("R7 write beats capture", 32'(cap_val), 32'h5A5A);
        pin_evt = 0; ticks(8);
        // R8 top mode holds value
        top_mode = 1;
        cap_wr_en = 1; cap_wr_data = 16'h1234; tick(); cap_wr_en = 0;
        run_event(0, 1, 0, "R8 top ignores rise");
        check("R8 top holds written", 32'(cap_val), 32'h1234);
        run_event(0, 0, 0, "R8 top ignores fall");
        top_mode = 0;

        // random mixed scenarios
        for (int it = 0; it < 40; it++) begin
            bit lvl, s, r, f;
            lvl = pin_evt;
            s = 1'($urandom); r = 1'($urandom); f = 1'($urandom);
            src_sel = s; edge_rise = r; filt_en = f;
            cnt_val = 16'($urandom);
            ticks(8);
            run_event(s, !lvl, edge_match(r, lvl, !lvl), "R1 R2 R3 R4 random");
            set_in(!s, !lvl);
            ticks(12);
        end

        done = 1;
        report();
        $finish;
    end
endmodule